// File: doc/BRIEF.md
# Dual-Branch Filter Datapath with Latency Balancing

This block takes two input sample streams and filters them along two parallel branches that meet at an adder. Branch A chains three FIR stages. Branch B has a single FIR stage. The adder's result goes through one more FIR stage to the output.

Every stage updates only on an enable strobe and registers its result. Each stage therefore adds one strobe of latency, and branch A arrives two strobes later than branch B. An internal sequencer issues the strobes. The block puts the two branches back in step in one of two ways, chosen at elaboration:

- **Register mode** delays branch B's result through two strobe-gated registers.
- **Control mode** lengthens branch B's sample window and loads its result register from a second enable. That enable repeats the base strobe but starts two strobes (eight clocks) later.

Either way, the output equals an ideal zero-latency model of the filter network delayed by three strobes. An output-valid pulse marks each new result once the longest path has filled.

Top module: `dualbr_top`

## Requirements
- R1: A synchronous active-high reset clears the phase counter. The base strobe fires every PERIOD (4) cycles, first on the 4th rising edge after reset is released. The inputs are sampled only at strobe edges, so changes between strobes are ignored.
- R2: Each stage is a 3-tap FIR. Tap k (k=0 is the newest sample) of stage s has coefficient s+k+1. The stages are numbered A1=0, A2=1, A3=2, B=3 and final=4. Each stage result wraps to its output width in two's complement.
- R3: Branch A is three stages in series and branch B is one stage. Their sum feeds the final stage. After strobe k, the output holds the ideal zero-latency network output for sample k-3, or zero when k<3.
- R4: The adder sign-extends both 12-bit branch results to 13 bits, so the sum never wraps, even for extreme inputs.
- R5: In register mode, branch B's result passes through two registers gated by the base strobe.
- R6: In control mode, branch B's result register loads only on a second enable. That enable coincides with base strobes from the third one after reset onward (eight cycles after the first).
- R7: Both modes produce the same output on every cycle for the same input streams.
- R8: The valid flag is a one-cycle pulse in the cycle that follows each base strobe from the fourth one on. It stays low before that.
- R9: While reset is held and in the cycle after it, the output is zero and the valid flag is low. A reset in mid-run restarts the strobe schedule, the fill count and the late start of the second enable.
- R10: The output changes only in the cycle that follows a base strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inA | input | DATA_W | Signed sample stream for branch A |
| inB | input | DATA_W | Signed sample stream for branch B |
| dout | output | DATA_W+1 | Signed filtered output |
| outValid | output | 1 | Pulses once for each new output sample after fill |

## Verification
Two events meet in one cycle in control mode. The late second enable first fires on the third base strobe, while branch A is still filling and before the valid flag has ever risen. A mid-run reset makes the same coincidence happen a second time.

The bench provokes this by running both modes side by side on identical inputs that change every cycle. It judges the result against a behavioural reference on every clock, and it checks that the two modes agree cycle for cycle. An impulse fed to one branch at a time checks the coefficients and the alignment of the branches across that boundary.

// File: rtl/dualbr_pkg.sv
package dualbr_pkg;

  typedef struct packed {
    logic baseEn;
    logic branchEn;
  } strobe_t;

  function automatic int coefOf(input int stage, input int tap);
    return stage + tap + 1;
  endfunction

endpackage

// File: rtl/fir_stage.sv
module fir_stage
  import dualbr_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 12,
  parameter int TAPS  = 3,
  parameter int SKIP  = 0,
  parameter int STAGE = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shiftEn,
  input  logic                    loadEn,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int DEPTH = TAPS - 1 + SKIP;
  localparam int ACC_W = IN_W + $clog2(TAPS + 1) + 8;

  logic signed [IN_W-1:0]  line   [DEPTH];
  logic signed [IN_W-1:0]  window [DEPTH+1];
  logic signed [ACC_W-1:0] acc;

  assign window[0] = din;
  for (genvar j = 1; j <= DEPTH; j++) begin : g_win
    assign window[j] = line[j-1];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      acc = acc + ACC_W'(window[k+SKIP]) * ACC_W'(coefOf(STAGE, k));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) line[j] <= '0;
      dout <= '0;
    end else begin
      if (shiftEn) begin
        line[0] <= din;
        for (int j = 1; j < DEPTH; j++) line[j] <= line[j-1];
      end
      if (loadEn) dout <= acc[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/dualbr_ctrl.sv
module dualbr_ctrl
  import dualbr_pkg::*;
#(
  parameter int PERIOD = 4,
  parameter int SKEW   = 2,
  parameter int FILL   = 3
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t ctrl,
  output logic    outValid
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int SAT   = (FILL > SKEW) ? FILL : SKEW;
  localparam int SC_W  = $clog2(SAT + 1);

  logic [CNT_W-1:0] phase;
  logic [SC_W-1:0]  strobeCnt;
  logic             baseEn;

  assign baseEn        = (phase == CNT_W'(PERIOD - 1));
  assign ctrl.baseEn   = baseEn;
  assign ctrl.branchEn = baseEn && (strobeCnt >= SC_W'(SKEW));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      strobeCnt <= '0;
      outValid  <= 1'b0;
    end else begin
      phase    <= baseEn ? '0 : phase + 1'b1;
      outValid <= baseEn && (strobeCnt >= SC_W'(FILL));
      if (baseEn && (strobeCnt != SC_W'(SAT))) strobeCnt <= strobeCnt + 1'b1;
    end
  end
endmodule

// File: rtl/dualbr_datapath.sv
module dualbr_datapath
  import dualbr_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int TAPS      = 3,
  parameter int A_STAGES  = 3,
  parameter bit CTRL_MODE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobe_t                  ctrl,
  input  logic signed [DATA_W-1:0] inA,
  input  logic signed [DATA_W-1:0] inB,
  output logic signed [DATA_W:0]   dout
);
  localparam int SKEW   = A_STAGES - 1;
  localparam int STG_B  = A_STAGES;
  localparam int STG_F  = A_STAGES + 1;

  logic signed [DATA_W-1:0] chainA [A_STAGES+1];
  logic signed [DATA_W-1:0] bAligned;
  logic signed [DATA_W:0]   sum;

  assign chainA[0] = inA;
  for (genvar i = 0; i < A_STAGES; i++) begin : g_branchA
    fir_stage #(.IN_W(DATA_W), .OUT_W(DATA_W), .TAPS(TAPS), .SKIP(0), .STAGE(i)) u_fir (
      .clk(clk), .rst(rst), .shiftEn(ctrl.baseEn), .loadEn(ctrl.baseEn),
      .din(chainA[i]), .dout(chainA[i+1])
    );
  end

  if (CTRL_MODE) begin : g_ctrlMode
    fir_stage #(.IN_W(DATA_W), .OUT_W(DATA_W), .TAPS(TAPS), .SKIP(SKEW), .STAGE(STG_B)) u_firB (
      .clk(clk), .rst(rst), .shiftEn(ctrl.baseEn), .loadEn(ctrl.branchEn),
      .din(inB), .dout(bAligned)
    );
  end else begin : g_regMode
    logic signed [DATA_W-1:0] bRaw;
    logic signed [DATA_W-1:0] pipe [SKEW];
    fir_stage #(.IN_W(DATA_W), .OUT_W(DATA_W), .TAPS(TAPS), .SKIP(0), .STAGE(STG_B)) u_firB (
      .clk(clk), .rst(rst), .shiftEn(ctrl.baseEn), .loadEn(ctrl.baseEn),
      .din(inB), .dout(bRaw)
    );
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < SKEW; j++) pipe[j] <= '0;
      end else if (ctrl.baseEn) begin
        pipe[0] <= bRaw;
        for (int j = 1; j < SKEW; j++) pipe[j] <= pipe[j-1];
      end
    end
    assign bAligned = pipe[SKEW-1];
  end

  assign sum = {chainA[A_STAGES][DATA_W-1], chainA[A_STAGES]} + {bAligned[DATA_W-1], bAligned};

  fir_stage #(.IN_W(DATA_W+1), .OUT_W(DATA_W+1), .TAPS(TAPS), .SKIP(0), .STAGE(STG_F)) u_firF (
    .clk(clk), .rst(rst), .shiftEn(ctrl.baseEn), .loadEn(ctrl.baseEn),
    .din(sum), .dout(dout)
  );
endmodule

// File: rtl/dualbr_top.sv
module dualbr_top
  import dualbr_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int TAPS      = 3,
  parameter int PERIOD    = 4,
  parameter int A_STAGES  = 3,
  parameter bit CTRL_MODE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] inA,
  input  logic signed [DATA_W-1:0] inB,
  output logic signed [DATA_W:0]   dout,
  output logic                     outValid
);
  localparam int SKEW = A_STAGES - 1;

  strobe_t ctrlBus;
  logic    baseEn;
  logic    branchEn;

  assign baseEn   = ctrlBus.baseEn;
  assign branchEn = ctrlBus.branchEn;

  dualbr_ctrl #(.PERIOD(PERIOD), .SKEW(SKEW), .FILL(A_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .ctrl(ctrlBus), .outValid(outValid)
  );

  dualbr_datapath #(.DATA_W(DATA_W), .TAPS(TAPS), .A_STAGES(A_STAGES), .CTRL_MODE(CTRL_MODE)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrlBus), .inA(inA), .inB(inB), .dout(dout)
  );
endmodule

// File: rtl/dualbr_chk.sv
module dualbr_chk #(
  parameter int PERIOD = 4,
  parameter int FILL   = 3,
  parameter int OUT_W  = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             baseEn,
  input logic             branchEn,
  input logic             outValid,
  input logic [OUT_W-1:0] dout
);
  localparam int SKEW = FILL - 1;

  int gap;
  int seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 0;
      seen <= 0;
    end else begin
      gap <= baseEn ? 0 : gap + 1;
      if (baseEn && seen < FILL + 1) seen <= seen + 1;
    end
  end

  p_strobe_gap_r1: assert property (@(posedge clk) disable iff (rst)
    baseEn |-> (gap == PERIOD - 1));
  p_strobe_due_r1: assert property (@(posedge clk) disable iff (rst)
    (gap == PERIOD - 1) |-> baseEn);
  p_branch_late_r6: assert property (@(posedge clk) disable iff (rst)
    branchEn |-> (baseEn && seen >= SKEW));
  p_branch_joins_r6: assert property (@(posedge clk) disable iff (rst)
    (baseEn && seen >= SKEW) |-> branchEn);
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);
  p_valid_fill_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (seen > FILL));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(baseEn) |-> $stable(dout));
endmodule

bind dualbr_top dualbr_chk #(.PERIOD(PERIOD), .FILL(A_STAGES), .OUT_W(DATA_W + 1)) u_chk (
  .clk(clk), .rst(rst), .baseEn(baseEn), .branchEn(branchEn),
  .outValid(outValid), .dout(dout)
);

// File: tb/dualbr_top_tb.sv
module dualbr_top_tb;
  localparam int W = 12;
  localparam int TAPS = 3;
  localparam int PERIOD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [W-1:0] inA = '0;
  logic signed [W-1:0] inB = '0;
  logic signed [W:0] doutReg, doutCtl;
  logic validReg, validCtl;

  int checks = 0;
  int errors = 0;
  string tag = "R9";
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dualbr_top #(.CTRL_MODE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .inA(inA), .inB(inB), .dout(doutReg), .outValid(validReg)
  );
  dualbr_top #(.CTRL_MODE(1'b1)) u_dutCtrl (
    .clk(clk), .rst(rst), .inA(inA), .inB(inB), .dout(doutCtl), .outValid(validCtl)
  );

  int xa[$], xb[$], a1[$], a2[$], a3[$], bq[$], sq[$], fq[$];
  int edgeCnt = 0;
  int expOut = 0;
  bit expValid = 1'b0;
  bit strobeEdge = 1'b0;

  function automatic int wrapTo(longint v, int w);
    longint m = longint'(1) << w;
    longint r = v & (m - 1);
    if (r >= m / 2) r = r - m;
    return int'(r);
  endfunction

  function automatic int firCalc(int stage, int q[$], int idx, int w);
    longint acc = 0;
    for (int k = 0; k < TAPS; k++)
      if (idx - k >= 0) acc += longint'(stage + k + 1) * q[idx - k];
    return wrapTo(acc, w);
  endfunction

  // Behavioural reference model of the ideal network plus strobe schedule
  always @(posedge clk) begin
    strobeEdge = 1'b0;
    if (rst) begin
      xa.delete(); xb.delete(); a1.delete(); a2.delete(); a3.delete();
      bq.delete(); sq.delete(); fq.delete();
      edgeCnt = 0; expOut = 0; expValid = 1'b0;
    end else begin
      int k;
      edgeCnt++;
      expValid = 1'b0;
      if (edgeCnt % PERIOD == 0) begin
        strobeEdge = 1'b1;
        xa.push_back(int'(inA));
        xb.push_back(int'(inB));
        k = xa.size() - 1;
        a1.push_back(firCalc(0, xa, k, W));
        a2.push_back(firCalc(1, a1, k, W));
        a3.push_back(firCalc(2, a2, k, W));
        bq.push_back(firCalc(3, xb, k, W));
        sq.push_back(a3[k] + bq[k]);
        fq.push_back(firCalc(4, sq, k, W + 1));
        expOut = (k >= 3) ? fq[k - 3] : 0;
        expValid = (k >= 3);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      string hold;
      hold = strobeEdge ? "" : " R10";
      check(int'(doutReg) == expOut, {"R5 R3 ", tag, hold, " reg-mode dout"}, int'(doutReg), expOut);
      check(int'(doutCtl) == expOut, {"R6 R3 ", tag, hold, " ctrl-mode dout"}, int'(doutCtl), expOut);
      check(doutReg == doutCtl, "R7 modes agree", int'(doutCtl), int'(doutReg));
      check(validReg == expValid && validCtl == expValid, {"R8 valid ", tag},
            int'(validReg) * 2 + int'(validCtl), int'(expValid) * 3);
    end
  end

  task automatic cycles(int n, int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (pat)
        0: begin inA = W'($urandom); inB = W'($urandom); end
        1: begin inA = '0; inB = '0; end
        2: begin inA = W'(2047); inB = W'(2047); end
        3: begin inA = -W'(2048); inB = -W'(2048); end
        4: begin inA = (i % 8 < 4) ? W'(2047) : -W'(2048); inB = -inA - W'(1); end
        5: begin inA = W'(1); inB = '0; end
        default: begin inA = '0; inB = W'(1); end
      endcase
    end
  endtask

  initial begin
    tag = "R9";
    cycles(3, 1);
    @(negedge clk);
    check(doutReg == 0 && doutCtl == 0, "R9 reset dout", int'(doutReg), 0);
    check(!validReg && !validCtl, "R9 reset valid", int'(validReg), 0);
    rst = 1'b0;
    tag = "R1";
    cycles(600, 0);
    tag = "R2";
    cycles(40, 1); cycles(4, 5); cycles(60, 1); cycles(4, 6); cycles(60, 1);
    tag = "R4";
    cycles(80, 2); cycles(80, 3); cycles(80, 4);
    tag = "R9";
    @(negedge clk); rst = 1'b1;
    cycles(2, 0);
    check(doutReg == 0 && doutCtl == 0, "R9 mid-run reset dout", int'(doutCtl), 0);
    check(!validReg && !validCtl, "R9 mid-run reset valid", int'(validCtl), 0);
    rst = 1'b0;
    cycles(40, 0);
    tag = "R1";
    cycles(200, 0);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule